// File: doc/BRIEF.md
# SDRAM power-up initialization sequencer

This block sits on the controller side of a single-data-rate SDRAM. It brings the memory from power-on to an idle, programmed state. From reset release it holds clock enable and every data mask lane high and keeps the command bus at no-operation for a stabilization pause. It then issues one precharge of all banks, one mode-register load and a configurable run of auto-refresh cycles. Each command is followed by the minimum gap the memory needs before the next one. A parameter picks whether the refreshes go before or after the mode-register load.

Every time limit is given in nanoseconds or microseconds and turned into whole clock cycles from the clock-frequency parameter, always rounding up. The command, address, bank, clock-enable, mask and done pins all come from one output register stage, so they stay aligned with each other. Once the last gap has run out, the block raises init_done_o and keeps the bus at no-operation until the next reset. At that point the normal memory controller takes over the pins.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_ni is low, the command pins {cs_n_o, ras_n_o, cas_n_o, we_n_o} show 4'b0111 (no-operation), cke_o is 1, every bit of dqm_o is 1, addr_o and ba_o are 0, and init_done_o is 0.
- R2: After reset release, the bus holds no-operation for a pause of ceil(PAUSE_US*CLK_MHZ) cycles. The first command other than no-operation appears on the output sample taken after rising edge PAUSE_CYC+1, counted from the first rising edge after release.
- R3: cke_o stays 1 and dqm_o stays all ones on every cycle from reset until init_done_o is high.
- R4: The first command is precharge-all: pins 4'b0010 with addr_o equal to 1<<10 (bit 10 high, all other bits low).
- R5: The command after the precharge-all comes exactly TRP cycles after it, where TRP = ceil(TRP_NS*CLK_MHZ/1000).
- R6: The mode-register load is issued exactly once, as pins 4'b0000, with addr_o equal to MODE_OP. ba_o is 0 on every cycle.
- R7: The next event after the mode-register load (a command or the rise of init_done_o) comes exactly MRD_CLK cycles after it.
- R8: Exactly REF_COUNT auto-refresh commands (pins 4'b0001) are issued. Any event that follows a refresh comes exactly TRC = ceil(TRC_NS*CLK_MHZ/1000) cycles after that refresh.
- R9: With REF_FIRST=0 the order is precharge-all, mode load, refreshes. With REF_FIRST=1 it is precharge-all, refreshes, mode load.
- R10: init_done_o rises exactly one required gap after the last command (TRC after the last refresh, or MRD_CLK after the mode load). After that it stays high and the bus shows only no-operation.
- R11: Every nanosecond limit is rounded up to whole cycles. At 125 MHz, 20 ns gives 3 cycles and 63 ns gives 8 cycles.
- R12: Asserting rst_ni low in the middle of the sequence returns all outputs to the R1 state. The full sequence, including the complete pause, then restarts after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Active-low asynchronous reset, starts the sequence on release |
| cke_o | output | 1 | Clock enable to the memory |
| dqm_o | output | DQM_W | Data mask lanes |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Address bus, carries bit 10 for precharge-all and the mode opcode |
| ba_o | output | BA_W | Bank address, held at zero |
| init_done_o | output | 1 | High once initialization is complete |

## Verification
The assertions check the following on every cycle:
- the gap timer counts down one step at a time;
- the refresh tally never exceeds REF_COUNT;
- a precharge-all from the state machine shows up one cycle later on the pins with bit 10 set;
- the cycle after a precharge-all or a mode load is always no-operation;
- init_done_o never falls, and the bus stays at no-operation while it is high.

Only the bench scenarios can show the exact length of the pause, the exact gap between each pair of commands with rounding up, the refresh count and the order chosen by REF_FIRST, and the restart after a reset in mid-sequence. Two instances with opposite ordering and different counts cover both orders.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS  = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PALL = 4'b0010,
    CMD_NOP  = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PALL,
    ST_WAIT_RP,
    ST_MRS,
    ST_WAIT_MRD,
    ST_REF,
    ST_WAIT_RC,
    ST_DONE
  } state_e;

  localparam int unsigned A10_BIT = 10;

  // nanoseconds to cycles, rounded up
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  // gaps shorter than two cycles are raised to two
  function automatic int unsigned min2(input int unsigned v);
    return (v < 2) ? 2 : v;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/init_gap_timer.sv
module init_gap_timer #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_VAL = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_W'(RST_VAL);
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

  // R2 R5 R8: waits shrink by exactly one per cycle
  a_r2_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/init_seq_fsm.sv
module init_seq_fsm
  import sdram_init_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned REF_COUNT = 8,
  parameter bit          REF_FIRST = 1'b0,
  parameter int unsigned TRP_LD    = 1,
  parameter int unsigned TRC_LD    = 6,
  parameter int unsigned MRD_LD    = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output cmd_e             cmd_o,
  output logic             done_o
);

  localparam int unsigned RC_W = $clog2(REF_COUNT + 1);
  localparam logic [RC_W-1:0] REF_LAST = RC_W'(REF_COUNT);

  state_e          state_q, state_d;
  logic [RC_W-1:0] ref_cnt_q;
  logic            refs_done;

  assign refs_done = (ref_cnt_q == REF_LAST);

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (state_q)
      ST_PAUSE:    if (zero_i) state_d = ST_PALL;
      ST_PALL: begin
        load_o     = 1'b1;
        load_val_o = CNT_W'(TRP_LD);
        state_d    = ST_WAIT_RP;
      end
      ST_WAIT_RP:  if (zero_i) state_d = REF_FIRST ? ST_REF : ST_MRS;
      ST_MRS: begin
        load_o     = 1'b1;
        load_val_o = CNT_W'(MRD_LD);
        state_d    = ST_WAIT_MRD;
      end
      ST_WAIT_MRD: if (zero_i) state_d = REF_FIRST ? ST_DONE : ST_REF;
      ST_REF: begin
        load_o     = 1'b1;
        load_val_o = CNT_W'(TRC_LD);
        state_d    = ST_WAIT_RC;
      end
      ST_WAIT_RC: begin
        if (zero_i) begin
          if (!refs_done)     state_d = ST_REF;
          else if (REF_FIRST) state_d = ST_MRS;
          else                state_d = ST_DONE;
        end
      end
      ST_DONE:     state_d = ST_DONE;
      default:     state_d = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_PAUSE;
      ref_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_REF) ref_cnt_q <= ref_cnt_q + 1'b1;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PALL: cmd_o = CMD_PALL;
      ST_MRS:  cmd_o = CMD_MRS;
      ST_REF:  cmd_o = CMD_REF;
      default: cmd_o = CMD_NOP;
    endcase
  end

  assign done_o = (state_q == ST_DONE);

  a_r8_ref_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_cnt_q <= REF_LAST);

  a_r8_no_ref_past_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refs_done |-> (cmd_o != CMD_REF));

endmodule

// File: rtl/init_pin_reg.sv
module init_pin_reg
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned BA_W    = 1,
  parameter int unsigned DQM_W   = 2,
  parameter logic [ADDR_W-1:0] MODE_OP = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic              done_i,
  output logic              cke_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic [3:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              done_o
);

  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    unique case (cmd_i)
      CMD_PALL: addr_d = ADDR_W'(1) << A10_BIT;
      CMD_MRS:  addr_d = MODE_OP;
      default:  addr_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o  <= CMD_NOP;
      addr_o <= '0;
      done_o <= 1'b0;
    end else begin
      cmd_o  <= cmd_i;
      addr_o <= addr_d;
      done_o <= done_i;
    end
  end

  // held high during the whole sequence so DQ stays high impedance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_o <= 1'b1;
      dqm_o <= '1;
    end else begin
      cke_o <= 1'b1;
      dqm_o <= '1;
    end
  end

  assign ba_o = '0;

  a_r10_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  a_r10_nop_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cmd_o == CMD_NOP));

  a_r5_pall_then_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_PALL) |=> (cmd_o == CMD_NOP));

  a_r7_mrs_then_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_MRS) |=> (cmd_o == CMD_NOP));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 125,
  parameter int unsigned PAUSE_US  = 200,
  parameter int unsigned TRP_NS    = 20,
  parameter int unsigned TRC_NS    = 63,
  parameter int unsigned MRD_CLK   = 2,
  parameter int unsigned REF_COUNT = 8,
  parameter bit          REF_FIRST = 1'b0,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BA_W      = 1,
  parameter int unsigned DQM_W     = 2,
  parameter logic [ADDR_W-1:0] MODE_OP = 12'h032
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              cke_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              init_done_o
);

  localparam int unsigned PAUSE_CYC = ns2cyc(PAUSE_US * 1000, CLK_MHZ);
  localparam int unsigned TRP_CYC   = min2(ns2cyc(TRP_NS, CLK_MHZ));
  localparam int unsigned TRC_CYC   = min2(ns2cyc(TRC_NS, CLK_MHZ));
  localparam int unsigned MRD_CYC   = min2(MRD_CLK);
  localparam int unsigned CNT_MAX   = max3(PAUSE_CYC, TRP_CYC, max3(TRC_CYC, MRD_CYC, 1));
  localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);

  logic             zero;
  logic             load;
  logic [CNT_W-1:0] load_val;
  cmd_e             seq_cmd;
  logic             seq_done;
  logic [3:0]       pin_cmd;

  init_gap_timer #(
    .CNT_W   (CNT_W),
    .RST_VAL (PAUSE_CYC - 1)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (zero)
  );

  init_seq_fsm #(
    .CNT_W     (CNT_W),
    .REF_COUNT (REF_COUNT),
    .REF_FIRST (REF_FIRST),
    .TRP_LD    (TRP_CYC - 2),
    .TRC_LD    (TRC_CYC - 2),
    .MRD_LD    (MRD_CYC - 2)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .zero_i     (zero),
    .load_o     (load),
    .load_val_o (load_val),
    .cmd_o      (seq_cmd),
    .done_o     (seq_done)
  );

  init_pin_reg #(
    .ADDR_W  (ADDR_W),
    .BA_W    (BA_W),
    .DQM_W   (DQM_W),
    .MODE_OP (MODE_OP)
  ) u_pins (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (seq_cmd),
    .done_i (seq_done),
    .cke_o  (cke_o),
    .dqm_o  (dqm_o),
    .cmd_o  (pin_cmd),
    .addr_o (addr_o),
    .ba_o   (ba_o),
    .done_o (init_done_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = pin_cmd;

  // R4: a precharge-all from the sequencer reaches the pins next cycle with bit 10 set
  a_r4_pall_on_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_cmd == CMD_PALL) |=> (pin_cmd == CMD_PALL && addr_o[A10_BIT]));

  // R3: clock enable and masks stay high until done
  a_r3_cke_dqm_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> (cke_o && (&dqm_o)));

endmodule

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;

  localparam logic [3:0] C_NOP  = 4'b0111;
  localparam logic [3:0] C_PALL = 4'b0010;
  localparam logic [3:0] C_REF  = 4'b0001;
  localparam logic [3:0] C_MRS  = 4'b0000;

  localparam int MHZ   = 125;
  localparam int P0_US = 2;
  localparam int P1_US = 1;
  localparam int TRP_NS = 20;
  localparam int TRC_NS = 63;
  localparam int NREF0 = 8;
  localparam int NREF1 = 3;
  localparam logic [11:0] MODE0 = 12'h032;
  localparam logic [11:0] MODE1 = 12'h227;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   finished = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  logic cke0, cs0, ras0, cas0, we0, dn0;
  logic [1:0] dqm0;
  logic [11:0] addr0;
  logic [0:0] ba0;
  logic cke1, cs1, ras1, cas1, we1, dn1;
  logic [1:0] dqm1;
  logic [11:0] addr1;
  logic [0:0] ba1;

  sdram_init_seq #(
    .CLK_MHZ(MHZ), .PAUSE_US(P0_US), .TRP_NS(TRP_NS), .TRC_NS(TRC_NS),
    .MRD_CLK(2), .REF_COUNT(NREF0), .REF_FIRST(1'b0),
    .ADDR_W(12), .BA_W(1), .DQM_W(2), .MODE_OP(MODE0)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cke_o(cke0), .dqm_o(dqm0),
    .cs_n_o(cs0), .ras_n_o(ras0), .cas_n_o(cas0), .we_n_o(we0),
    .addr_o(addr0), .ba_o(ba0), .init_done_o(dn0)
  );

  sdram_init_seq #(
    .CLK_MHZ(MHZ), .PAUSE_US(P1_US), .TRP_NS(TRP_NS), .TRC_NS(TRC_NS),
    .MRD_CLK(2), .REF_COUNT(NREF1), .REF_FIRST(1'b1),
    .ADDR_W(12), .BA_W(1), .DQM_W(2), .MODE_OP(MODE1)
  ) u1 (
    .clk_i(clk), .rst_ni(rst_n), .cke_o(cke1), .dqm_o(dqm1),
    .cs_n_o(cs1), .ras_n_o(ras1), .cas_n_o(cas1), .we_n_o(we1),
    .addr_o(addr1), .ba_o(ba1), .init_done_o(dn1)
  );

  // event logs, sampled on the falling edge
  logic [3:0]  lc0 [16];
  int          lt0 [16];
  logic [11:0] la0 [16];
  int n0, dc0;
  bit pin_bad0, ba_bad0, aft_bad0;
  logic [3:0]  lc1 [16];
  int          lt1 [16];
  logic [11:0] la1 [16];
  int n1, dc1;
  bit pin_bad1, ba_bad1, aft_bad1;
  logic [3:0] c0, c1;

  always @(negedge clk) begin
    c0 = {cs0, ras0, cas0, we0};
    if (!rst_n) begin
      n0 = 0; dc0 = -1; pin_bad0 = 0; ba_bad0 = 0; aft_bad0 = 0;
    end else begin
      if (dc0 < 0 && (cke0 !== 1'b1 || dqm0 !== 2'b11)) pin_bad0 = 1;
      if (ba0 !== 1'b0) ba_bad0 = 1;
      if (dc0 >= 0 && (c0 !== C_NOP || dn0 !== 1'b1)) aft_bad0 = 1;
      if (dn0 === 1'b1 && dc0 < 0) dc0 = cyc;
      if (dc0 < 0 && c0 !== C_NOP && n0 < 16) begin
        lc0[n0] = c0; lt0[n0] = cyc; la0[n0] = addr0; n0++;
      end
    end
  end

  always @(negedge clk) begin
    c1 = {cs1, ras1, cas1, we1};
    if (!rst_n) begin
      n1 = 0; dc1 = -1; pin_bad1 = 0; ba_bad1 = 0; aft_bad1 = 0;
    end else begin
      if (dc1 < 0 && (cke1 !== 1'b1 || dqm1 !== 2'b11)) pin_bad1 = 1;
      if (ba1 !== 1'b0) ba_bad1 = 1;
      if (dc1 >= 0 && (c1 !== C_NOP || dn1 !== 1'b1)) aft_bad1 = 1;
      if (dn1 === 1'b1 && dc1 < 0) dc1 = cyc;
      if (dc1 < 0 && c1 !== C_NOP && n1 < 16) begin
        lc1[n1] = c1; lt1[n1] = cyc; la1[n1] = addr1; n1++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cdiv(input int ns);
    return (ns * MHZ + 999) / 1000;
  endfunction

  task automatic check_reset_pins(input string tag);
    check({cs0, ras0, cas0, we0} === C_NOP && {cs1, ras1, cas1, we1} === C_NOP,
          {tag, " cmd nop"}, {cs0, ras0, cas0, we0}, C_NOP);
    check(cke0 === 1'b1 && cke1 === 1'b1, {tag, " cke"}, cke0, 1);
    check(dqm0 === 2'b11 && dqm1 === 2'b11, {tag, " dqm"}, dqm0, 3);
    check(addr0 === 12'h0 && addr1 === 12'h0 && ba0 === 1'b0 && ba1 === 1'b0,
          {tag, " addr/ba"}, addr0, 0);
    check(dn0 === 1'b0 && dn1 === 1'b0, {tag, " done low"}, dn0, 0);
  endtask

  task automatic check_log(input string nm, input int n, input logic [3:0] lc [16],
                           input int lt [16], input logic [11:0] la [16], input int dc,
                           input bit pin_bad, input bit ba_bad, input bit aft_bad,
                           input int p_us, input int nref, input bit ref_first,
                           input logic [11:0] mode);
    logic [3:0] ec [16];
    int et [16];
    int k, t, p, trp, trc, exp_done;
    p   = p_us * MHZ;
    trp = cdiv(TRP_NS);
    trc = cdiv(TRC_NS);
    // R11: rounding up at 125 MHz
    check(trp == 3 && trc == 8, {nm, " R11 rounded gaps"}, trp * 100 + trc, 308);
    ec[0] = C_PALL; et[0] = p + 1; k = 1; t = p + 1;
    if (ref_first) begin
      for (int i = 0; i < nref; i++) begin
        t = t + ((i == 0) ? trp : trc);
        ec[k] = C_REF; et[k] = t; k++;
      end
      t = t + trc; ec[k] = C_MRS; et[k] = t; k++;
      exp_done = t + 2;
    end else begin
      t = t + trp; ec[k] = C_MRS; et[k] = t; k++;
      for (int i = 0; i < nref; i++) begin
        t = t + ((i == 0) ? 2 : trc);
        ec[k] = C_REF; et[k] = t; k++;
      end
      exp_done = t + trc;
    end
    check(n == k, {nm, " R8 R9 command count"}, n, k);
    check(n > 0 && lt[0] == p + 1, {nm, " R2 pause length"}, lt[0], p + 1);
    check(n > 0 && lc[0] == C_PALL && la[0] == 12'h400, {nm, " R4 precharge-all a10"},
          la[0], 12'h400);
    for (int i = 1; i < k && i < n; i++) begin
      check(lc[i] == ec[i], {nm, " R9 order"}, lc[i], ec[i]);
      if (lc[i - 1] == C_PALL)
        check(lt[i] == et[i], {nm, " R5 gap after precharge"}, lt[i] - lt[i - 1], trp);
      else if (lc[i - 1] == C_MRS)
        check(lt[i] == et[i], {nm, " R7 gap after mode load"}, lt[i] - lt[i - 1], 2);
      else
        check(lt[i] == et[i], {nm, " R8 gap after refresh"}, lt[i] - lt[i - 1], trc);
      if (lc[i] == C_MRS)
        check(la[i] == mode, {nm, " R6 mode opcode"}, la[i], mode);
    end
    check(dc == exp_done, {nm, " R10 done timing"}, dc, exp_done);
    check(!aft_bad, {nm, " R10 nop and done held after done"}, aft_bad, 0);
    check(!pin_bad, {nm, " R3 cke/dqm high"}, pin_bad, 0);
    check(!ba_bad, {nm, " R6 bank zero"}, ba_bad, 0);
  endtask

  task automatic wait_done(input string tag);
    int w;
    w = 0;
    while (!(dn0 === 1'b1 && dn1 === 1'b1) && w < 2000) begin
      @(negedge clk); w++;
    end
    repeat (20) @(negedge clk);
    check(w < 2000, {tag, " R10 done reached"}, w, 0);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_pins("R1 reset");
  endtask

  task automatic t_full_run();
    @(negedge clk); rst_n = 1'b1;
    wait_done("run");
    check_log("u0", n0, lc0, lt0, la0, dc0, pin_bad0, ba_bad0, aft_bad0,
              P0_US, NREF0, 1'b0, MODE0);
    check_log("u1", n1, lc1, lt1, la1, dc1, pin_bad1, ba_bad1, aft_bad1,
              P1_US, NREF1, 1'b1, MODE1);
  endtask

  task automatic t_mid_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    while (cyc < 280) @(negedge clk);
    check(dn0 === 1'b0 && n0 > 2, "R12 u0 mid-sequence", n0, 3);
    rst_n = 1'b0;
    #1;
    check_reset_pins("R12 async reset");
    repeat (3) @(negedge clk);
    check_reset_pins("R12 held reset");
    rst_n = 1'b1;
    wait_done("R12 rerun");
    check(n0 > 0 && lt0[0] == P0_US * MHZ + 1, "R12 pause restarted", lt0[0], P0_US * MHZ + 1);
    check_log("u0 rerun", n0, lc0, lt0, la0, dc0, pin_bad0, ba_bad0, aft_bad0,
              P0_US, NREF0, 1'b0, MODE0);
    check_log("u1 rerun", n1, lc1, lt1, la1, dc1, pin_bad1, ba_bad1, aft_bad1,
              P1_US, NREF1, 1'b1, MODE1);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_full_run();
    t_mid_reset();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule